// File: doc/BRIEF.md
# Capture-compare timer with toggle output

A single 16-bit timer channel that counts up on an external prescaler tick while its run bit is set, wrapping from 0xFFFF to 0x0000. Two compare registers are watched by two comparators. Each raises a one-cycle match interrupt on the tick that brings the counter to its value. Two capture registers snapshot the counter. Capture 0 is taken by software through the control register, and capture 1 is taken on an already-detected strobe input. A single output flip-flop drives the timer output level. It can toggle on either match or either capture, each source with its own enable, and a 2-bit command can invert, set or clear it.

Software uses a byte-wide register bus. Writes reach the control byte, the output control byte and the compare bytes. Reads return the capture registers one byte at a time, low byte first. Reading a low byte copies the matching high byte into a shadow, so the high-byte read that follows stays consistent with it even if a new capture lands in between. A small readout state machine tracks this. RD_IDLE means no shadow is held. RD_HELD0 and RD_HELD1 mean the shadow belongs to capture 0 or capture 1.

The readout transitions are:
- A low-byte read of capture N goes from any state to RD_HELDN.
- Any high-byte read goes from any state back to RD_IDLE.
- In every other cycle the state is held.

A high-byte read returns the shadow only when the state names the same capture register. Otherwise it returns the live high byte.

Top module: `cc_timer`

Register map (4-bit address, 8-bit data):

| Address | Register | Contents |
|---|---|---|
| 0x0 | Control | bit0 = run. Writing bit1 = 0 requests a software capture. |
| 0x1 | Output control | bits[1:0] = command. bit2 enables toggling on match 0, bit3 on match 1, bit4 on capture 0, bit5 on capture 1. |
| 0x2 / 0x3 | Compare 0 | low byte / high byte |
| 0x4 / 0x5 | Compare 1 | low byte / high byte |
| 0x8 / 0x9 | Capture 0 | low byte / high byte (read-only) |
| 0xA / 0xB | Capture 1 | low byte / high byte (read-only) |

## Requirements
- R1: The 16-bit counter resets to 0. It advances by one on each cycle where tick is 1 and the run bit (control bit0) is 1, wraps from 0xFFFF to 0x0000, and holds its value while run is 0.
- R2: Compare registers reset to 0xFFFF and are written one byte at a time: compare 0 low/high at 0x2/0x3, compare 1 low/high at 0x4/0x5.
- R3: irq_match0 (irq_match1) is high for exactly one cycle, the cycle after the tick edge that makes the counter equal to compare 0 (compare 1). It is low in every other cycle.
- R4: A write to address 0x0 with bit1 = 0 copies the counter into capture 0, but only if run was already 1 before that write. A write with bit1 = 1, or a write while run is 0, leaves capture 0 unchanged. Captures reset to 0.
- R5: A one-cycle pulse on cap1_strobe copies the counter into capture 1.
- R6: Bus writes to the capture addresses 0x8 to 0xB change neither capture register.
- R7: Capture bytes are read at 0x8/0x9 (capture 0, low/high) and 0xA/0xB (capture 1, low/high), with rdata valid in the cycle rd_en is high. After a low-byte read, the next high-byte read of the same capture returns the high byte as it was at the low-byte read. Further high reads return the live value.
- R8: Output command field (address 0x1 bits[1:0]): 00 inverts tmr_out, 01 sets it to 1, 10 clears it to 0, 11 leaves it unchanged. Each command acts once, on the write edge.
- R9: tmr_out inverts once for each enabled event in a cycle (address 0x1: bit2 match 0, bit3 match 1, bit4 capture 0, bit5 capture 1). Disabled events have no effect, and two enabled events in the same cycle cancel.
- R10: If an event coincides with a command write, a set or clear command overrides the event toggles. An invert command adds one more inversion to them.
- R11: After reset both interrupts are low, and rdata is 0 whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler tick enable |
| cap1_strobe | input | 1 | Capture 1 request pulse |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 4 | Bus register address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data (combinational) |
| irq_match0 | output | 1 | Compare 0 match pulse |
| irq_match1 | output | 1 | Compare 1 match pulse |
| tmr_out | output | 1 | Output flip-flop level |

## Verification
The comparators are swept over several compare-value placements relative to the running counter: near and far, both distinct, and both equal. Paired with every combination of the two match enables, these separate a missing or doubled pulse from a wrong toggle gate, and show that simultaneous events cancel. Software captures are tried with the run bit set, with bit1 held high, and while stopped, which distinguishes the capture gate from the counter hold. The shadow readout is probed with a second capture landing between the low and high reads, and a count through 0xFFFF exposes the wrap together with the match logic. Commands are issued both alone and on the same cycle as a capture strobe, to separate override from accumulation.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

    localparam int unsigned N_CH  = 2;
    localparam int unsigned N_EVT = 2 * N_CH;

    localparam logic [3:0] ADDR_CTRL     = 4'h0;
    localparam logic [3:0] ADDR_FFCTL    = 4'h1;
    localparam logic [3:0] ADDR_CMP_BASE = 4'h2;

    typedef enum logic [1:0] {
        FF_INVERT = 2'b00,
        FF_SET    = 2'b01,
        FF_CLEAR  = 2'b10,
        FF_HOLD   = 2'b11
    } ff_cmd_e;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_HELD0 = 2'd1,
        RD_HELD1 = 2'd2
    } rd_state_e;

endpackage

// File: rtl/cc_timer_counter.sv
module cc_timer_counter #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned N_CMP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_val [N_CMP],
    output logic [CNT_W-1:0] cnt,
    output logic [N_CMP-1:0] hit,
    output logic [N_CMP-1:0] irq
);

    logic             adv;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt;

    assign adv = run && tick;
    assign nxt = cnt_q + 1'b1;
    assign cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= nxt;
        end
    end

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cnt_q));

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        logic irq_q;

        assign hit[g] = adv && (nxt == cmp_val[g]);
        assign irq[g] = irq_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq_q <= 1'b0;
            end else begin
                irq_q <= hit[g];
            end
        end

        assert_match_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
            irq_q |-> $past(adv));
    end

endmodule

// File: rtl/cc_timer_capture.sv
module cc_timer_capture
    import cc_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [N_CH-1:0]  load,
    input  logic             rd_en,
    input  logic [3:0]       rd_addr,
    output logic [7:0]       rdata
);

    localparam int unsigned BYTE_W = CNT_W / 2;

    logic [CNT_W-1:0]  cap_q [N_CH];
    logic [BYTE_W-1:0] shadow_q;
    logic [BYTE_W-1:0] cap_hi;
    logic [BYTE_W-1:0] cap_lo;
    rd_state_e         state_q;
    rd_state_e         state_d;
    logic              rd_cap;
    logic              ch;
    logic              hi;
    logic              own_shadow;

    assign rd_cap = rd_en && (rd_addr[3:2] == 2'b10);
    assign ch     = rd_addr[1];
    assign hi     = rd_addr[0];
    assign cap_hi = cap_q[ch][CNT_W-1:BYTE_W];
    assign cap_lo = cap_q[ch][BYTE_W-1:0];

    for (genvar g = 0; g < N_CH; g++) begin : g_cap
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cap_q[g] <= '0;
            end else if (load[g]) begin
                cap_q[g] <= cnt;
            end
        end

        assert_cap_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
            load[g] |=> cap_q[g] == $past(cnt));

        assert_cap_readonly_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !load[g] |=> $stable(cap_q[g]));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: begin
                if (rd_cap && !hi) state_d = ch ? RD_HELD1 : RD_HELD0;
            end
            RD_HELD0, RD_HELD1: begin
                if (rd_cap && !hi)     state_d = ch ? RD_HELD1 : RD_HELD0;
                else if (rd_cap && hi) state_d = RD_IDLE;
            end
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RD_IDLE;
            shadow_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_cap && !hi) shadow_q <= cap_hi;
        end
    end

    assign own_shadow = ((state_q == RD_HELD0) && !ch) || ((state_q == RD_HELD1) && ch);

    always_comb begin
        rdata = '0;
        if (rd_cap) begin
            if (!hi)             rdata = cap_lo;
            else if (own_shadow) rdata = shadow_q;
            else                 rdata = cap_hi;
        end
    end

    assert_shadow_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cap && !hi) |=> shadow_q == $past(cap_hi));

    assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0);

endmodule

// File: rtl/cc_timer_outff.sv
module cc_timer_outff
    import cc_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  ff_cmd_e          cmd,
    input  logic [N_EVT-1:0] events,
    input  logic [N_EVT-1:0] enables,
    output logic             ff_o
);

    logic ff_q;
    logic ff_d;
    logic flip;

    assign flip = ^(events & enables);
    assign ff_o = ff_q;

    always_comb begin
        ff_d = ff_q ^ flip;
        if (cmd_valid) begin
            unique case (cmd)
                FF_INVERT: ff_d = ~(ff_q ^ flip);
                FF_SET:    ff_d = 1'b1;
                FF_CLEAR:  ff_d = 1'b0;
                FF_HOLD:   ff_d = ff_q ^ flip;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        ff_q <= ff_d;
    end

    assert_ff_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == FF_SET) |=> ff_q);

    assert_ff_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == FF_CLEAR) |=> !ff_q);

    assert_ff_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && (events & enables) == '0) |=> $stable(ff_q));

endmodule

// File: rtl/cc_timer.sv
module cc_timer
    import cc_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cap1_strobe,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq_match0,
    output logic       irq_match1,
    output logic       tmr_out
);

    localparam int unsigned BYTE_W = CNT_W / 2;

    logic             run_q;
    logic [CNT_W-1:0] cmp_q [N_CH];
    logic [N_EVT-1:0] ff_en_q;
    logic [CNT_W-1:0] cnt;
    logic [N_CH-1:0]  hit;
    logic [N_CH-1:0]  irq;
    logic [N_CH-1:0]  cap_load;
    logic [N_EVT-1:0] events;
    logic             wr_ctrl;
    logic             wr_ff;
    logic             sw_cap;

    assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
    assign wr_ff   = wr_en && (addr == ADDR_FFCTL);
    assign sw_cap  = wr_ctrl && !wdata[1] && run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            ff_en_q <= '0;
        end else begin
            if (wr_ctrl) run_q   <= wdata[0];
            if (wr_ff)   ff_en_q <= wdata[2 +: N_EVT];
        end
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_cmpreg
        localparam logic [3:0] A_LO = ADDR_CMP_BASE + 4'(2 * c);
        localparam logic [3:0] A_HI = A_LO + 4'd1;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_q[c] <= '1;
            end else if (wr_en && addr == A_LO) begin
                cmp_q[c][BYTE_W-1:0] <= wdata;
            end else if (wr_en && addr == A_HI) begin
                cmp_q[c][CNT_W-1:BYTE_W] <= wdata;
            end
        end
    end

    assign cap_load = {cap1_strobe, sw_cap};
    assign events   = {cap_load, hit};

    cc_timer_counter #(.CNT_W(CNT_W), .N_CMP(N_CH)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .tick    (tick),
        .cmp_val (cmp_q),
        .cnt     (cnt),
        .hit     (hit),
        .irq     (irq)
    );

    cc_timer_capture #(.CNT_W(CNT_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt),
        .load    (cap_load),
        .rd_en   (rd_en),
        .rd_addr (addr),
        .rdata   (rdata)
    );

    cc_timer_outff u_outff (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (wr_ff),
        .cmd       (ff_cmd_e'(wdata[1:0])),
        .events    (events),
        .enables   (ff_en_q),
        .ff_o      (tmr_out)
    );

    assign irq_match0 = irq[0];
    assign irq_match1 = irq[1];

    assert_swcap_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wdata[1] && !run_q && !cap1_strobe) |-> cap_load == '0);

    assert_irq_reset_R11: assert property (@(posedge clk)
        $past(!rst_n) |-> (irq == '0));

endmodule

// File: tb/cc_timer_test.sv
module cc_timer_test;

    logic       clk = 1'b0;
    logic       rst_n, tick, cap1_strobe, wr_en, rd_en;
    logic [3:0] addr;
    logic [7:0] wdata, rdata;
    logic       irq_match0, irq_match1, tmr_out;

    always #10 clk = ~clk;

    cc_timer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cap1_strobe(cap1_strobe),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_match0(irq_match0), .irq_match1(irq_match1), .tmr_out(tmr_out)
    );

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [15:0] cnt_m;
    logic        run_m;
    logic [15:0] cmp_m [2];
    logic [15:0] cap_m [2];
    logic [3:0]  en_m;
    logic        ff_m;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic apply_cmd(input logic [1:0] c, input logic flip);
        case (c)
            2'b00: ff_m = ~(ff_m ^ flip);
            2'b01: ff_m = 1'b1;
            2'b10: ff_m = 1'b0;
            default: ff_m = ff_m ^ flip;
        endcase
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        case (a)
            4'h0: begin
                if (!d[1] && run_m) begin
                    cap_m[0] = cnt_m;
                    ff_m = ff_m ^ en_m[2];
                end
                run_m = d[0];
            end
            4'h1: begin apply_cmd(d[1:0], 1'b0); en_m = d[5:2]; end
            4'h2: cmp_m[0][7:0]  = d;
            4'h3: cmp_m[0][15:8] = d;
            4'h4: cmp_m[1][7:0]  = d;
            4'h5: cmp_m[1][15:8] = d;
            default: ;
        endcase
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_cap(input int ch, output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_rd(4'(8 + 2 * ch), lo);
        bus_rd(4'(9 + 2 * ch), hi);
        v = {hi, lo};
    endtask

    task automatic wr_cmp(input int ch, input logic [15:0] v);
        bus_wr(4'(2 + 2 * ch), v[7:0]);
        bus_wr(4'(3 + 2 * ch), v[15:8]);
    endtask

    // one tick with R3/R9 checks at the following negedge, then one idle cycle
    task automatic do_tick();
        logic h0, h1;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        if (run_m) cnt_m = cnt_m + 16'd1;
        h0 = run_m && (cnt_m == cmp_m[0]);
        h1 = run_m && (cnt_m == cmp_m[1]);
        ff_m = ff_m ^ (h0 & en_m[0]) ^ (h1 & en_m[1]);
        check("R3 irq_match0 on tick", irq_match0, h0);
        check("R3 irq_match1 on tick", irq_match1, h1);
        check("R9 tmr_out after match events", tmr_out, ff_m);
        @(negedge clk);
        check("R3 irq_match0 single cycle", irq_match0, 0);
        check("R3 irq_match1 single cycle", irq_match1, 0);
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
        if (run_m) cnt_m = cnt_m + 16'(n);
    endtask

    task automatic strobe_cmd(input logic do_cmd, input logic [7:0] d);
        @(negedge clk);
        cap1_strobe = 1'b1;
        wr_en = do_cmd; addr = 4'h1; wdata = d;
        cap_m[1] = cnt_m;
        if (do_cmd) begin
            apply_cmd(d[1:0], en_m[3]);
            en_m = d[5:2];
        end else begin
            ff_m = ff_m ^ en_m[3];
        end
        @(negedge clk);
        cap1_strobe = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        #(20 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v, old;
        logic [7:0]  b;
        int          n;
        rst_n = 1'b0; tick = 1'b0; cap1_strobe = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        addr = '0; wdata = '0;
        cnt_m = '0; run_m = 1'b0; en_m = '0; ff_m = 1'b0;
        cmp_m[0] = 16'hFFFF; cmp_m[1] = 16'hFFFF; cap_m[0] = '0; cap_m[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check("R11 irq_match0 after reset", irq_match0, 0);
        check("R11 irq_match1 after reset", irq_match1, 0);
        check("R11 rdata idle", rdata, 0);
        rd_cap(0, v); check("R4 capture 0 reset value", v, 0);
        rd_cap(1, v); check("R5 capture 1 reset value", v, 0);

        // R8 commands
        bus_wr(4'h1, 8'h02); check("R8 clear", tmr_out, 0);
        bus_wr(4'h1, 8'h01); check("R8 set", tmr_out, 1);
        repeat (3) @(negedge clk); check("R8 set acts once", tmr_out, 1);
        bus_wr(4'h1, 8'h00); check("R8 invert", tmr_out, 0);
        repeat (3) @(negedge clk); check("R8 invert acts once", tmr_out, 0);
        bus_wr(4'h1, 8'h03); check("R8 code 11 no-op", tmr_out, 0);
        bus_wr(4'h1, 8'h01); bus_wr(4'h1, 8'h03); check("R8 no-op after set", tmr_out, 1);

        // R2/R3/R9 sweep over compare placements and enable combinations
        bus_wr(4'h0, 8'h03);
        for (int s = 0; s < 5; s++) begin
            if (s == 4) begin
                wr_cmp(0, cnt_m + 16'd2); wr_cmp(1, cnt_m + 16'd2);
                bus_wr(4'h1, 8'h0F);
            end else begin
                wr_cmp(0, cnt_m + 16'(1 + s)); wr_cmp(1, cnt_m + 16'(3 + 2 * s));
                bus_wr(4'h1, 8'((s << 2) | 3));
            end
            for (int t = 0; t < 10; t++) do_tick();
        end
        bus_wr(4'h1, 8'h03);

        // R4 software capture
        bus_wr(4'h0, 8'h01); rd_cap(0, v); check("R4 software capture", v, cap_m[0]);
        old = cap_m[0];
        bus_wr(4'h0, 8'h03); run_ticks(5);
        rd_cap(0, v); check("R4 bit1=1 no capture", v, old);
        bus_wr(4'h0, 8'h02); run_ticks(7);
        bus_wr(4'h0, 8'h00); rd_cap(0, v); check("R4 no capture while stopped", v, old);
        bus_wr(4'h0, 8'h03); bus_wr(4'h0, 8'h01);
        rd_cap(0, v); check("R1 counter held while stopped", v, cnt_m);

        // R6 read-only captures
        for (int a = 8; a < 12; a++) bus_wr(4'(a), 8'hA5);
        rd_cap(0, v); check("R6 capture 0 unwritable", v, cap_m[0]);
        rd_cap(1, v); check("R6 capture 1 unwritable", v, cap_m[1]);

        // R5 strobe capture with capture-1 toggle enabled
        bus_wr(4'h1, 8'h23); run_ticks(3);
        strobe_cmd(1'b0, 8'h00);
        check("R9 toggle on capture 1", tmr_out, ff_m);
        rd_cap(1, v); check("R5 strobe capture", v, cap_m[1]);

        // R7 shadow readout
        run_ticks(300); bus_wr(4'h0, 8'h01); old = cap_m[0];
        check("R9 disabled capture 0 event", tmr_out, ff_m);
        bus_rd(4'h8, b); check("R7 low byte", b, old[7:0]);
        run_ticks(256); bus_wr(4'h0, 8'h01);
        bus_rd(4'h9, b); check("R7 high byte from shadow", b, old[15:8]);
        bus_rd(4'h9, b); check("R7 high byte live", b, cap_m[0][15:8]);
        bus_rd(4'h8, b);
        bus_rd(4'hB, b); check("R7 other channel high live", b, cap_m[1][15:8]);

        // R10 command with coincident event
        bus_wr(4'h1, 8'h21); check("R10 preset", tmr_out, 1);
        strobe_cmd(1'b1, 8'h21); check("R10 set overrides toggle", tmr_out, ff_m);
        strobe_cmd(1'b1, 8'h20); check("R10 invert plus toggle", tmr_out, ff_m);
        strobe_cmd(1'b1, 8'h22); check("R10 clear overrides toggle", tmr_out, ff_m);
        rd_cap(1, v); check("R5 strobe during command", v, cap_m[1]);

        // R1 wrap with match at zero
        bus_wr(4'h1, 8'h03);
        wr_cmp(0, 16'h0000); wr_cmp(1, 16'h0001);
        n = int'(16'hFFFE - cnt_m);
        if (n > 0) run_ticks(n);
        bus_wr(4'h1, 8'h07);
        for (int t = 0; t < 4; t++) do_tick();
        bus_wr(4'h1, 8'h03); bus_wr(4'h0, 8'h01);
        rd_cap(0, v); check("R1 wrap through 0xFFFF", v, 16'h0002);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule